// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Front End

This block sits between a host bus and the channel and timer logic of a two-channel asynchronous serial controller. The host presents a 4-bit address, an 8-bit write bus and active-low read and write strobes. The block decodes each access into per-channel registers (two mode registers, clock select, command, transmit holding) and shared registers (auxiliary control, interrupt mask, counter preset, scratch, output configuration, output port). It returns status, receive data, input-change, interrupt status, counter value and input-pin values on reads.

A single address often means two different things. The meaning depends on whether the access is a read or a write. The two mode registers of a channel share one address. A per-channel pointer picks between them. The first access to that address hits mode register 1, and every later access hits mode register 2 until a command resets the pointer. Some accesses act as commands through their side effects: they start or stop the counter, or set or clear output-port bits. Each access acts exactly once. The block detects the falling edge of a strobe synchronously, so holding a strobe low does not repeat the action. Read data is captured on that same edge and held until the next read.

Top module: `duart_regfile`

## Requirements
- R1: Synchronous active-high reset clears the mode, clock select, auxiliary, interrupt mask, preset, output configuration and output port registers to zero. It also sets both mode pointers to mode register 1 and drives all command pulses low.
- R2: Writes are decoded as follows: address 1/9 sets clock select A/B, 4 sets auxiliary control, 5 sets interrupt mask, 6/7 set preset upper/lower byte, 12 sets scratch and 13 sets output configuration. Each value appears on its output one clock after the strobe's falling edge is sampled.
- R3: Reads are decoded as follows: address 1/9 returns status A/B, 3/11 receive data A/B, 4 input change, 5 interrupt status, 6/7 counter upper/lower byte, 12 scratch and 13 {0, pins[6:0]}. The value is captured one clock after the falling edge and held until the next read.
- R4: Addresses 0 (channel A) and 8 (channel B) reach mode register 1 while the channel's pointer is at 1 and mode register 2 otherwise. Any read or write of that address moves the pointer to 2, and the pointer stays at 2.
- R5: A write to the command register (address 2 for A, 10 for B) whose bits 6:4 equal 3'b001 returns that channel's pointer to mode register 1.
- R6: The two channels' pointers and registers are independent. An access to one channel never changes the other channel.
- R7: A read of address 14 raises the counter-start pulse and a read of address 15 raises the counter-stop pulse. Each pulse lasts exactly one clock.
- R8: A write to address 14 sets the output-port bits that are written as 1. A write to address 15 clears the output-port bits that are written as 1. Bits written as 0 keep their value.
- R9: Side effects fire once per access. A strobe held low for several clocks causes no further pointer advance, register update or pulse.
- R10: A command write gives a one-clock command pulse with the written value. A transmit-holding write (address 3/11) gives a one-clock transmit pulse with the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| rdata | output | 8 | Captured read data |
| stat_a | input | 8 | Channel A status |
| stat_b | input | 8 | Channel B status |
| rxd_a | input | 8 | Channel A received byte |
| rxd_b | input | 8 | Channel B received byte |
| in_chg | input | 8 | Input change value |
| irq_stat | input | 8 | Interrupt status value |
| ct_value | input | 16 | Counter current value |
| in_pins | input | 7 | Input pins |
| mode1_a | output | 8 | Channel A mode register 1 |
| mode2_a | output | 8 | Channel A mode register 2 |
| mode1_b | output | 8 | Channel B mode register 1 |
| mode2_b | output | 8 | Channel B mode register 2 |
| csel_a | output | 8 | Channel A clock select |
| csel_b | output | 8 | Channel B clock select |
| cmd_a | output | 8 | Channel A last command |
| cmd_b | output | 8 | Channel B last command |
| cmd_a_stb | output | 1 | Channel A command pulse |
| cmd_b_stb | output | 1 | Channel B command pulse |
| txd_a | output | 8 | Channel A transmit byte |
| txd_b | output | 8 | Channel B transmit byte |
| tx_a_stb | output | 1 | Channel A transmit pulse |
| tx_b_stb | output | 1 | Channel B transmit pulse |
| aux_ctl | output | 8 | Auxiliary control |
| irq_mask | output | 8 | Interrupt mask |
| ct_preset | output | 16 | Counter preset |
| out_cfg | output | 8 | Output configuration |
| out_port | output | 8 | Output port bits |
| ct_start | output | 1 | Counter start pulse |
| ct_stop | output | 1 | Counter stop pulse |

## Verification
The pointer is exercised with runs of writes and with reads to the mode address, both after reset and after a pointer-reset command. These runs show whether the pointer advances on any access, stays at register 2, and returns only on the command. Both channels take the same patterns with different data, so any crossover between channels shows up. Every read address is driven with a distinct input value, which separates a wrong decode from a right one. Strobes held low for several clocks show whether pulses, pointer moves and set/clear writes are repeated. Output-port writes with overlapping and all-zero masks separate a masked update from a plain overwrite.

// File: rtl/duart_pkg.sv
package duart_pkg;
    localparam int AW  = 4;
    localparam int DW  = 8;
    localparam int NCH = 2;
    localparam int PW  = 7;
    localparam int CTW = 2 * DW;

    typedef enum logic [2:0] {
        L_MODE = 3'd0,
        L_STCS = 3'd1,
        L_CMD  = 3'd2,
        L_HOLD = 3'd3
    } chan_loc_e;

    typedef enum logic [AW-1:0] {
        G_IPC_AUX   = 4'd4,
        G_ISR_IMR   = 4'd5,
        G_CT_HI     = 4'd6,
        G_CT_LO     = 4'd7,
        G_SCRATCH   = 4'd12,
        G_PINS_OCFG = 4'd13,
        G_SET_START = 4'd14,
        G_CLR_STOP  = 4'd15
    } glob_addr_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } access_t;

    localparam logic [2:0] CMD_PTR_RESET = 3'b001;

    function automatic logic is_ptr_reset(input logic [DW-1:0] c);
        return c[6:4] == CMD_PTR_RESET;
    endfunction

    function automatic logic is_chan_addr(input logic [AW-1:0] a);
        return a[2] == 1'b0;
    endfunction

    function automatic int unsigned chan_of(input logic [AW-1:0] a);
        return int'(a[3]);
    endfunction
endpackage

// File: rtl/duart_strobe_edge.sv
module duart_strobe_edge
    import duart_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_n,
    input  logic          wr_n,
    output access_t       acc
);
    logic rd_n_q, wr_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
        end else begin
            rd_n_q <= rd_n;
            wr_n_q <= wr_n;
        end
    end

    always_comb begin
        acc.rd   = !rst && rd_n_q && !rd_n;
        acc.wr   = !rst && wr_n_q && !wr_n;
        acc.addr = addr;
        acc.data = wdata;
    end
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
    import duart_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  access_t       acc,
    output logic [DW-1:0] mr1,
    output logic [DW-1:0] mr2,
    output logic [DW-1:0] csel,
    output logic [DW-1:0] cmd,
    output logic          cmd_stb,
    output logic [DW-1:0] txd,
    output logic          tx_stb,
    output logic          ptr
);
    logic      mine;
    chan_loc_e loc;

    always_comb begin
        mine = is_chan_addr(acc.addr) && (chan_of(acc.addr) == CH);
        loc  = chan_loc_e'(acc.addr[2:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mr1     <= '0;
            mr2     <= '0;
            csel    <= '0;
            cmd     <= '0;
            cmd_stb <= 1'b0;
            txd     <= '0;
            tx_stb  <= 1'b0;
            ptr     <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            tx_stb  <= 1'b0;
            if (mine && acc.rd && loc == L_MODE) begin
                ptr <= 1'b1;
            end
            if (mine && acc.wr) begin
                case (loc)
                    L_MODE: begin
                        if (ptr) mr2 <= acc.data;
                        else     mr1 <= acc.data;
                        ptr <= 1'b1;
                    end
                    L_STCS: csel <= acc.data;
                    L_CMD: begin
                        cmd     <= acc.data;
                        cmd_stb <= 1'b1;
                        if (is_ptr_reset(acc.data)) ptr <= 1'b0;
                    end
                    L_HOLD: begin
                        txd    <= acc.data;
                        tx_stb <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/duart_shared_regs.sv
module duart_shared_regs
    import duart_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  access_t        acc,
    output logic [DW-1:0]  aux_ctl,
    output logic [DW-1:0]  irq_mask,
    output logic [CTW-1:0] ct_preset,
    output logic [DW-1:0]  scratch,
    output logic [DW-1:0]  out_cfg,
    output logic [DW-1:0]  out_port,
    output logic           ct_start,
    output logic           ct_stop
);
    logic       glob;
    glob_addr_e ga;

    always_comb begin
        glob = !is_chan_addr(acc.addr) || acc.addr == AW'(G_SCRATCH)
               || acc.addr == AW'(G_PINS_OCFG);
        ga   = glob_addr_e'(acc.addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            aux_ctl   <= '0;
            irq_mask  <= '0;
            ct_preset <= '0;
            scratch   <= '0;
            out_cfg   <= '0;
            out_port  <= '0;
            ct_start  <= 1'b0;
            ct_stop   <= 1'b0;
        end else begin
            ct_start <= acc.rd && ga == G_SET_START;
            ct_stop  <= acc.rd && ga == G_CLR_STOP;
            if (acc.wr && glob) begin
                case (ga)
                    G_IPC_AUX:   aux_ctl            <= acc.data;
                    G_ISR_IMR:   irq_mask           <= acc.data;
                    G_CT_HI:     ct_preset[CTW-1:DW] <= acc.data;
                    G_CT_LO:     ct_preset[DW-1:0]  <= acc.data;
                    G_SCRATCH:   scratch            <= acc.data;
                    G_PINS_OCFG: out_cfg            <= acc.data;
                    G_SET_START: out_port           <= out_port | acc.data;
                    G_CLR_STOP:  out_port           <= out_port & ~acc.data;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/duart_read_mux.sv
module duart_read_mux
    import duart_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  access_t                 acc,
    input  logic [NCH-1:0]          ptr,
    input  logic [NCH-1:0][DW-1:0]  mr1,
    input  logic [NCH-1:0][DW-1:0]  mr2,
    input  logic [NCH-1:0][DW-1:0]  stat,
    input  logic [NCH-1:0][DW-1:0]  rxd,
    input  logic [DW-1:0]           in_chg,
    input  logic [DW-1:0]           irq_stat,
    input  logic [CTW-1:0]          ct_value,
    input  logic [DW-1:0]           scratch,
    input  logic [PW-1:0]           in_pins,
    output logic [DW-1:0]           rdata
);
    logic [DW-1:0] sel;
    int unsigned   ch;

    always_comb begin
        ch  = chan_of(acc.addr);
        sel = '0;
        if (is_chan_addr(acc.addr)) begin
            case (chan_loc_e'(acc.addr[2:0]))
                L_MODE:  sel = ptr[ch] ? mr2[ch] : mr1[ch];
                L_STCS:  sel = stat[ch];
                L_HOLD:  sel = rxd[ch];
                default: sel = '0;
            endcase
        end else begin
            case (glob_addr_e'(acc.addr))
                G_IPC_AUX:   sel = in_chg;
                G_ISR_IMR:   sel = irq_stat;
                G_CT_HI:     sel = ct_value[CTW-1:DW];
                G_CT_LO:     sel = ct_value[DW-1:0];
                G_SCRATCH:   sel = scratch;
                G_PINS_OCFG: sel = {{(DW-PW){1'b0}}, in_pins};
                default:     sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (acc.rd) rdata <= sel;
    end
endmodule

// File: rtl/duart_regfile.sv
module duart_regfile
    import duart_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  addr,
    input  logic [7:0]  wdata,
    input  logic        rd_n,
    input  logic        wr_n,
    output logic [7:0]  rdata,
    input  logic [7:0]  stat_a,
    input  logic [7:0]  stat_b,
    input  logic [7:0]  rxd_a,
    input  logic [7:0]  rxd_b,
    input  logic [7:0]  in_chg,
    input  logic [7:0]  irq_stat,
    input  logic [15:0] ct_value,
    input  logic [6:0]  in_pins,
    output logic [7:0]  mode1_a,
    output logic [7:0]  mode2_a,
    output logic [7:0]  mode1_b,
    output logic [7:0]  mode2_b,
    output logic [7:0]  csel_a,
    output logic [7:0]  csel_b,
    output logic [7:0]  cmd_a,
    output logic [7:0]  cmd_b,
    output logic        cmd_a_stb,
    output logic        cmd_b_stb,
    output logic [7:0]  txd_a,
    output logic [7:0]  txd_b,
    output logic        tx_a_stb,
    output logic        tx_b_stb,
    output logic [7:0]  aux_ctl,
    output logic [7:0]  irq_mask,
    output logic [15:0] ct_preset,
    output logic [7:0]  out_cfg,
    output logic [7:0]  out_port,
    output logic        ct_start,
    output logic        ct_stop
);
    access_t                acc;
    logic [NCH-1:0]         ptr_v;
    logic [NCH-1:0][DW-1:0] mr1_v, mr2_v, csel_v, cmd_v, txd_v;
    logic [NCH-1:0]         cmd_stb_v, tx_stb_v;
    logic [NCH-1:0][DW-1:0] stat_v, rxd_v;
    logic [DW-1:0]          scratch;

    duart_strobe_edge i_edge (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .rd_n(rd_n), .wr_n(wr_n), .acc(acc)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        duart_chan_regs #(.CH(c)) i_chan (
            .clk(clk), .rst(rst), .acc(acc),
            .mr1(mr1_v[c]), .mr2(mr2_v[c]), .csel(csel_v[c]),
            .cmd(cmd_v[c]), .cmd_stb(cmd_stb_v[c]),
            .txd(txd_v[c]), .tx_stb(tx_stb_v[c]), .ptr(ptr_v[c])
        );
    end

    duart_shared_regs i_shared (
        .clk(clk), .rst(rst), .acc(acc),
        .aux_ctl(aux_ctl), .irq_mask(irq_mask), .ct_preset(ct_preset),
        .scratch(scratch), .out_cfg(out_cfg), .out_port(out_port),
        .ct_start(ct_start), .ct_stop(ct_stop)
    );

    assign stat_v = {stat_b, stat_a};
    assign rxd_v  = {rxd_b, rxd_a};

    duart_read_mux i_rmux (
        .clk(clk), .rst(rst), .acc(acc), .ptr(ptr_v),
        .mr1(mr1_v), .mr2(mr2_v), .stat(stat_v), .rxd(rxd_v),
        .in_chg(in_chg), .irq_stat(irq_stat), .ct_value(ct_value),
        .scratch(scratch), .in_pins(in_pins), .rdata(rdata)
    );

    assign mode1_a   = mr1_v[0];
    assign mode2_a   = mr2_v[0];
    assign mode1_b   = mr1_v[1];
    assign mode2_b   = mr2_v[1];
    assign csel_a    = csel_v[0];
    assign csel_b    = csel_v[1];
    assign cmd_a     = cmd_v[0];
    assign cmd_b     = cmd_v[1];
    assign cmd_a_stb = cmd_stb_v[0];
    assign cmd_b_stb = cmd_stb_v[1];
    assign txd_a     = txd_v[0];
    assign txd_b     = txd_v[1];
    assign tx_a_stb  = tx_stb_v[0];
    assign tx_b_stb  = tx_stb_v[1];
endmodule

// File: rtl/duart_regfile_chk.sv
module duart_regfile_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] addr,
    input logic       rd_n,
    input logic       wr_n,
    input logic       ptr_a,
    input logic       ptr_b,
    input logic [7:0] mode1_a,
    input logic [7:0] csel_a,
    input logic [7:0] irq_mask,
    input logic [7:0] out_port,
    input logic       ct_start,
    input logic       ct_stop,
    input logic       cmd_a_stb
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (out_port == 8'h00 && mode1_a == 8'h00 && csel_a == 8'h00
                 && irq_mask == 8'h00 && !ptr_a && !ptr_b && !ct_start && !cmd_a_stb));

    a_r4_ptr_rise_on_mode_addr: assert property (@(posedge clk) disable iff (rst)
        $rose(ptr_a) |-> $past(addr) == 4'd0);

    a_r5_ptr_fall_on_cmd: assert property (@(posedge clk) disable iff (rst)
        $fell(ptr_b) |-> ($past(addr) == 4'd10 && !$past(wr_n)));

    a_r7_start_one_clock: assert property (@(posedge clk) disable iff (rst)
        ct_start |=> !ct_start);

    a_r7_stop_one_clock: assert property (@(posedge clk) disable iff (rst)
        ct_stop |=> !ct_stop);

    a_r8_port_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
        wr_n |=> $stable(out_port));

    a_r9_start_from_fall: assert property (@(posedge clk) disable iff (rst)
        ct_start |-> (!$past(rd_n) && $past(rd_n, 2)));

    a_r10_cmd_one_clock: assert property (@(posedge clk) disable iff (rst)
        cmd_a_stb |=> !cmd_a_stb);
endmodule

bind duart_regfile duart_regfile_chk i_chk (
    .clk(clk), .rst(rst), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .ptr_a(ptr_v[0]), .ptr_b(ptr_v[1]), .mode1_a(mode1_a), .csel_a(csel_a),
    .irq_mask(irq_mask), .out_port(out_port), .ct_start(ct_start),
    .ct_stop(ct_stop), .cmd_a_stb(cmd_a_stb)
);

// File: tb/test_duart_regfile.sv
module test_duart_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  rdata;
    logic [7:0]  stat_a = 8'h81, stat_b = 8'h18, rxd_a = 8'h42, rxd_b = 8'h24;
    logic [7:0]  in_chg = 8'h0C, irq_stat = 8'h70;
    logic [15:0] ct_value = 16'hBEEF;
    logic [6:0]  in_pins = 7'h55;
    logic [7:0]  mode1_a, mode2_a, mode1_b, mode2_b, csel_a, csel_b, cmd_a, cmd_b;
    logic        cmd_a_stb, cmd_b_stb, tx_a_stb, tx_b_stb, ct_start, ct_stop;
    logic [7:0]  txd_a, txd_b, aux_ctl, irq_mask, out_cfg, out_port;
    logic [15:0] ct_preset;

    always #4 clk = ~clk;

    duart_regfile i_duart_regfile (.*);

    typedef struct {
        int          sel;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    function automatic logic [15:0] observe(input int sel);
        case (sel)
            0:  return {8'h0, rdata};
            1:  return {15'h0, ct_start};
            2:  return {15'h0, ct_stop};
            3:  return {8'h0, out_port};
            4:  return {8'h0, mode1_a};
            5:  return {8'h0, mode2_a};
            6:  return {8'h0, mode1_b};
            7:  return {8'h0, mode2_b};
            8:  return {8'h0, csel_a};
            9:  return {8'h0, csel_b};
            10: return {8'h0, aux_ctl};
            11: return {8'h0, irq_mask};
            12: return ct_preset;
            13: return {15'h0, cmd_a_stb};
            14: return {8'h0, cmd_a};
            15: return {15'h0, tx_a_stb};
            16: return {8'h0, txd_a};
            17: return {8'h0, out_cfg};
            18: return {15'h0, cmd_b_stb};
            19: return {8'h0, cmd_b};
            default: return 16'hDEAD;
        endcase
    endfunction

    task automatic expect_out(input int sel, input logic [15:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] got;
            it  = q.pop_front();
            got = observe(it.sel);
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
            end
        end
    end

    // Start an access; returns at the negedge after the edge that sampled the fall.
    task automatic start_acc(input bit is_wr, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_acc();
        rd_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        start_acc(1, a, d);
        end_acc();
    endtask

    task automatic rd_expect(input logic [3:0] a, input logic [7:0] exp, input string req);
        start_acc(0, a, 8'h00);
        expect_out(0, {8'h0, exp}, req);
        end_acc();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        expect_out(4, 16'h0, "R1 mode1_a");
        expect_out(8, 16'h0, "R1 csel_a");
        expect_out(11, 16'h0, "R1 irq_mask");
        expect_out(3, 16'h0, "R1 out_port");
        expect_out(12, 16'h0, "R1 ct_preset");
        expect_out(1, 16'h0, "R1 ct_start");
        rd_expect(4'd0, 8'h00, "R1 mode read after reset");

        // R4 pointer: after the reset read, pointer is at MR2
        wr(4'd0, 8'h55);
        expect_out(5, 16'h55, "R4 write after read goes to MR2");
        expect_out(4, 16'h00, "R4 MR1 untouched");
        wr(4'd2, 8'h10);
        // R5 pointer back to MR1
        wr(4'd0, 8'h13);
        expect_out(4, 16'h13, "R5 MR1 after pointer reset");
        wr(4'd0, 8'h07);
        expect_out(5, 16'h07, "R4 second write hits MR2");
        wr(4'd0, 8'h66);
        expect_out(5, 16'h66, "R4 pointer stays at MR2");
        expect_out(4, 16'h13, "R4 MR1 kept");
        rd_expect(4'd0, 8'h66, "R4 read at MR2");
        wr(4'd2, 8'h14);
        expect_out(4, 16'h13, "R5 cmd bits 6:4=001 with other bits set");
        rd_expect(4'd0, 8'h13, "R5 read MR1 after reset");
        rd_expect(4'd0, 8'h66, "R4 read advances to MR2");
        wr(4'd2, 8'h20);
        rd_expect(4'd0, 8'h66, "R5 other command leaves pointer");

        // R6 channel independence
        wr(4'd8, 8'h22);
        expect_out(6, 16'h22, "R6 B MR1");
        expect_out(4, 16'h13, "R6 A MR1 unchanged");
        wr(4'd8, 8'h33);
        expect_out(7, 16'h33, "R6 B MR2");
        expect_out(5, 16'h66, "R6 A MR2 unchanged");
        wr(4'd10, 8'h10);
        rd_expect(4'd0, 8'h66, "R6 B pointer reset leaves A at MR2");
        rd_expect(4'd8, 8'h22, "R6 B back at MR1");
        start_acc(1, 4'd10, 8'h91);
        expect_out(18, 16'h1, "R10 cmd_b pulse");
        expect_out(19, 16'h91, "R10 cmd_b value");
        expect_out(13, 16'h0, "R6 no cmd_a pulse");
        end_acc();

        // R2 write decode
        wr(4'd1, 8'hBB);  expect_out(8, 16'hBB, "R2 csel_a");
        wr(4'd9, 8'hCC);  expect_out(9, 16'hCC, "R2 csel_b");
        expect_out(8, 16'hBB, "R2 csel_a kept");
        wr(4'd4, 8'h5A);  expect_out(10, 16'h5A, "R2 aux_ctl");
        wr(4'd5, 8'h3C);  expect_out(11, 16'h3C, "R2 irq_mask");
        wr(4'd6, 8'h12);
        wr(4'd7, 8'h34);  expect_out(12, 16'h1234, "R2 ct_preset");
        wr(4'd13, 8'h0F); expect_out(17, 16'h0F, "R2 out_cfg");
        wr(4'd12, 8'h99);

        // R3 read decode
        rd_expect(4'd12, 8'h99, "R3 scratch");
        rd_expect(4'd1, 8'h81, "R3 stat_a");
        rd_expect(4'd9, 8'h18, "R3 stat_b");
        rd_expect(4'd3, 8'h42, "R3 rxd_a");
        rd_expect(4'd11, 8'h24, "R3 rxd_b");
        rd_expect(4'd4, 8'h0C, "R3 in_chg");
        rd_expect(4'd5, 8'h70, "R3 irq_stat");
        rd_expect(4'd6, 8'hBE, "R3 ct upper");
        rd_expect(4'd7, 8'hEF, "R3 ct lower");
        rd_expect(4'd13, 8'h55, "R3 pins");
        in_pins = 7'h7F;
        rd_expect(4'd13, 8'h7F, "R3 pins top bit zero");
        @(negedge clk);
        expect_out(0, 16'h7F, "R3 rdata held");

        // R7 / R9 counter commands with held strobe
        start_acc(0, 4'd14, 8'h00);
        expect_out(1, 16'h1, "R7 start pulse");
        expect_out(2, 16'h0, "R7 no stop pulse");
        @(negedge clk);
        expect_out(1, 16'h0, "R9 start not repeated");
        @(negedge clk);
        expect_out(1, 16'h0, "R9 start still low");
        end_acc();
        start_acc(0, 4'd15, 8'h00);
        expect_out(2, 16'h1, "R7 stop pulse");
        @(negedge clk);
        expect_out(2, 16'h0, "R7 stop one clock");
        end_acc();

        // R8 set / clear output port
        wr(4'd14, 8'h0F); expect_out(3, 16'h0F, "R8 set");
        wr(4'd14, 8'hA0); expect_out(3, 16'hAF, "R8 set keeps zeros");
        wr(4'd15, 8'h03); expect_out(3, 16'hAC, "R8 clear");
        wr(4'd15, 8'h00); expect_out(3, 16'hAC, "R8 clear with zero mask");

        // R9 held writes, R10 pulses
        start_acc(1, 4'd2, 8'h10);
        expect_out(13, 16'h1, "R10 cmd_a pulse");
        expect_out(14, 16'h10, "R10 cmd_a value");
        @(negedge clk);
        expect_out(13, 16'h0, "R9 cmd_a not repeated");
        end_acc();
        start_acc(1, 4'd0, 8'h77);
        @(negedge clk);
        @(negedge clk);
        end_acc();
        expect_out(4, 16'h77, "R9 held write hits MR1");
        expect_out(5, 16'h66, "R9 held write does not reach MR2");
        start_acc(1, 4'd3, 8'h5E);
        expect_out(15, 16'h1, "R10 tx pulse");
        expect_out(16, 16'h5E, "R10 tx byte");
        @(negedge clk);
        expect_out(15, 16'h0, "R10 tx one clock");
        end_acc();

        // R1 reset again mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_out(3, 16'h0, "R1 out_port after reset");
        expect_out(10, 16'h0, "R1 aux after reset");
        expect_out(17, 16'h0, "R1 out_cfg after reset");
        rd_expect(4'd0, 8'h00, "R1 pointer at MR1 after reset");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule